// File: doc/BRIEF.md
# Warp Load Coalescer

The block accepts one load request for a whole warp: a byte address for each lane, a mask of active lanes and a granularity select. Every active lane reads one 4-byte word. The block folds the lanes into the fewest aligned memory requests at the selected size. It then issues those requests, one per handshake, in ascending address order on a downstream valid/ready channel.

After the last request of a warp has been taken, the block gives a one-cycle report. The report holds the number of requests issued and the bus utilisation. Utilisation is the useful bytes divided by the bytes moved, expressed in thousandths of a percent. A memory pipeline uses the requests to fetch lines or segments. It uses the report to tune access patterns.

Top module: `warp_coalescer`

## Requirements
- R1: With `gran_i` = 0 each request covers an aligned 128-byte line, so `txn_addr_o` bits [6:0] are zero.
- R2: With `gran_i` = 1 each request covers an aligned 32-byte segment, so `txn_addr_o` bits [4:0] are zero.
- R3: Each distinct aligned region touched by an active lane is requested exactly once. No other region is requested.
- R4: Requests leave in strictly ascending address order. `txn_last_o` is high on the final request of a warp and only on that request.
- R5: While `txn_valid_o` is high and `txn_ready_i` is low, `txn_valid_o`, `txn_addr_o` and `txn_last_o` hold their values.
- R6: `req_ready_o` is low from the cycle after a warp with active lanes is accepted until the cycle after its last request handshake. A warp is accepted only when `req_valid_i` and `req_ready_o` are both high.
- R7: Lanes with a clear mask bit have no effect. A warp with an all-zero mask issues no request, gives no report, and leaves `req_ready_o` high.
- R8: `stat_valid_o` pulses for exactly one cycle, in the cycle after the last request handshake. `stat_cnt_o` then holds the number of requests issued.
- R9: `util_o` equals floor(4 × D × 100000 / (N × G)). Here D is the number of distinct 4-byte words addressed by active lanes (address bits [1:0] ignored), N is the request count, and G is 128 or 32. 100% reads as 100000.
- R10: After reset `req_ready_o` is high and `txn_valid_o` and `stat_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Warp request valid |
| req_ready_o | output | 1 | Block can accept a warp |
| lane_addr_i | input | 1024 | Lane byte addresses, lane k at bits [32k+31:32k] |
| lane_mask_i | input | 32 | Active lane mask |
| gran_i | input | 1 | 0: 128-byte line, 1: 32-byte segment |
| txn_valid_o | output | 1 | Memory request valid |
| txn_ready_i | input | 1 | Downstream accepts request |
| txn_addr_o | output | 32 | Aligned request base address |
| txn_last_o | output | 1 | Final request of the warp |
| stat_valid_o | output | 1 | Report pulse |
| stat_cnt_o | output | 6 | Requests issued for the warp |
| util_o | output | 17 | Utilisation in thousandths of a percent |

## Verification
A lane left pending after its region was sent would show at the ports as a repeated address. It would break the ascending order one handshake later, and the report would arrive late with a count that is too high. A lane cleared too early would drop a region and show as a missing address. The useful-word count is latched at accept, so an error in it only appears in `util_o` at the report pulse. For that reason the warps include duplicate-address, scattered and partly masked lanes, each with a known exact utilisation.

// File: rtl/wcoal_pkg.sv
package wcoal_pkg;
  typedef enum logic {
    GRAN_LINE = 1'b0,
    GRAN_SEG  = 1'b1
  } gran_e;
endpackage

// File: rtl/wcoal_word_dedup.sv
// counts distinct words addressed by active lanes
module wcoal_word_dedup #(
  parameter int LANES   = 32,
  parameter int ADDR_W  = 32,
  parameter int WORD_SH = 2,
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic [LANES*ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]        mask_i,
  output logic [CNT_W-1:0]        uniq_cnt_o
);
  localparam logic [ADDR_W-1:0] WORD_MSK = ~ADDR_W'((1 << WORD_SH) - 1);

  logic [LANES-1:0] first;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic dup;
    always_comb begin
      dup = 1'b0;
      for (int j = 0; j < i; j++)
        if (mask_i[j] && ((addr_i[j*ADDR_W +: ADDR_W] & WORD_MSK) ==
                          (addr_i[i*ADDR_W +: ADDR_W] & WORD_MSK)))
          dup = 1'b1;
    end
    assign first[i] = mask_i[i] & ~dup;
  end

  always_comb begin
    uniq_cnt_o = '0;
    for (int i = 0; i < LANES; i++) uniq_cnt_o = uniq_cnt_o + CNT_W'(first[i]);
  end
endmodule

// File: rtl/wcoal_min_pick.sv
// lowest pending region, lanes that share it, and whether others remain
module wcoal_min_pick #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32
) (
  input  logic [LANES*ADDR_W-1:0] key_i,
  input  logic [LANES-1:0]        pend_i,
  output logic [ADDR_W-1:0]       min_o,
  output logic [LANES-1:0]        hit_o,
  output logic                    more_o
);
  always_comb begin
    min_o = '1;
    for (int i = 0; i < LANES; i++)
      if (pend_i[i] && key_i[i*ADDR_W +: ADDR_W] < min_o) min_o = key_i[i*ADDR_W +: ADDR_W];
    more_o = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      hit_o[i] = pend_i[i] && (key_i[i*ADDR_W +: ADDR_W] == min_o);
      if (pend_i[i] && !hit_o[i]) more_o = 1'b1;
    end
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import wcoal_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int WORD_B     = 4,
  parameter int LINE_B     = 128,
  parameter int SEG_B      = 32,
  parameter int UTIL_SCALE = 100000,
  localparam int CNT_W     = $clog2(LANES + 1),
  localparam int UTIL_W    = $clog2(UTIL_SCALE + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [LANES*ADDR_W-1:0] lane_addr_i,
  input  logic [LANES-1:0]        lane_mask_i,
  input  logic                    gran_i,
  output logic                    txn_valid_o,
  input  logic                    txn_ready_i,
  output logic [ADDR_W-1:0]       txn_addr_o,
  output logic                    txn_last_o,
  output logic                    stat_valid_o,
  output logic [CNT_W-1:0]        stat_cnt_o,
  output logic [UTIL_W-1:0]       util_o
);
  localparam int WORD_SH = $clog2(WORD_B);
  localparam int LINE_SH = $clog2(LINE_B);
  localparam int SEG_SH  = $clog2(SEG_B);
  localparam logic [ADDR_W-1:0] LINE_MSK = ~ADDR_W'(LINE_B - 1);
  localparam logic [ADDR_W-1:0] SEG_MSK  = ~ADDR_W'(SEG_B - 1);

  logic                    busy_q;
  logic [LANES-1:0]        pend_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  gran_e                   gran_q;
  logic [CNT_W-1:0]        useful_q, cnt_q, uniq_cnt;
  logic                    stat_valid_q;
  logic [CNT_W-1:0]        stat_cnt_q;
  logic [UTIL_W-1:0]       util_q;

  logic [LANES*ADDR_W-1:0] key;
  logic [LANES-1:0]        hit;
  logic [ADDR_W-1:0]       min_key;
  logic                    more, accept, hs, done;
  logic [31:0]             num_w, den_w, quo_w;

  for (genvar i = 0; i < LANES; i++) begin : g_key
    assign key[i*ADDR_W +: ADDR_W] = addr_q[i*ADDR_W +: ADDR_W] &
                                     ((gran_q == GRAN_SEG) ? SEG_MSK : LINE_MSK);
  end

  wcoal_word_dedup #(.LANES(LANES), .ADDR_W(ADDR_W), .WORD_SH(WORD_SH)) u_dedup (
    .addr_i(lane_addr_i), .mask_i(lane_mask_i), .uniq_cnt_o(uniq_cnt)
  );

  wcoal_min_pick #(.LANES(LANES), .ADDR_W(ADDR_W)) u_pick (
    .key_i(key), .pend_i(pend_q), .min_o(min_key), .hit_o(hit), .more_o(more)
  );

  assign req_ready_o  = ~busy_q;
  assign accept       = req_valid_i & req_ready_o;
  assign txn_valid_o  = busy_q;
  assign txn_addr_o   = min_key;
  assign txn_last_o   = ~more;
  assign hs           = txn_valid_o & txn_ready_i;
  assign done         = hs & ~more;
  assign stat_valid_o = stat_valid_q;
  assign stat_cnt_o   = stat_cnt_q;
  assign util_o       = util_q;

  always_comb begin
    num_w = 32'(useful_q) * 32'(WORD_B) * 32'(UTIL_SCALE);
    den_w = (32'(cnt_q) + 32'd1) << ((gran_q == GRAN_SEG) ? SEG_SH : LINE_SH);
    quo_w = num_w / den_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= 1'b0;
      pend_q       <= '0;
      addr_q       <= '0;
      gran_q       <= GRAN_LINE;
      useful_q     <= '0;
      cnt_q        <= '0;
      stat_valid_q <= 1'b0;
      stat_cnt_q   <= '0;
      util_q       <= '0;
    end else begin
      stat_valid_q <= done;
      if (accept) begin
        busy_q   <= |lane_mask_i;
        pend_q   <= lane_mask_i;
        addr_q   <= lane_addr_i;
        gran_q   <= gran_e'(gran_i);
        useful_q <= uniq_cnt;
        cnt_q    <= '0;
      end else if (hs) begin
        pend_q <= pend_q & ~hit;
        cnt_q  <= cnt_q + 1'b1;
        if (done) begin
          busy_q     <= 1'b0;
          stat_cnt_q <= cnt_q + 1'b1;
          util_q     <= UTIL_W'(quo_w);
        end
      end
    end
  end

  // R1
  line_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && gran_q == GRAN_LINE |-> txn_addr_o[LINE_SH-1:0] == '0);
  // R2
  seg_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && gran_q == GRAN_SEG |-> txn_addr_o[SEG_SH-1:0] == '0);
  // R4
  ascend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && !txn_last_o |=> txn_valid_o && (txn_addr_o > $past(txn_addr_o)));
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_addr_o) && $stable(txn_last_o));
  // R6
  no_accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> !req_ready_o);
  // R7
  empty_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && lane_mask_i == '0 |=> !txn_valid_o && req_ready_o);
  // R8
  stat_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |=> !stat_valid_o);
  // R9
  util_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |-> util_o <= UTIL_W'(UTIL_SCALE) && stat_cnt_o != '0);
endmodule

// File: tb/warp_coalescer_tb_top.sv
`timescale 1ns/1ps
module warp_coalescer_tb_top;
  localparam int L = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [L*32-1:0] lane_addr = '0;
  logic [L-1:0]  lane_mask = '0;
  logic          gran = 1'b0;
  logic          txn_valid, txn_ready = 1'b0, txn_last;
  logic [31:0]   txn_addr;
  logic          stat_valid;
  logic [5:0]    stat_cnt;
  logic [16:0]   util;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  warp_coalescer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .lane_addr_i(lane_addr), .lane_mask_i(lane_mask), .gran_i(gran),
    .txn_valid_o(txn_valid), .txn_ready_i(txn_ready), .txn_addr_o(txn_addr),
    .txn_last_o(txn_last), .stat_valid_o(stat_valid), .stat_cnt_o(stat_cnt), .util_o(util)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural model: sorted distinct regions, distinct words, exact utilisation
  task automatic run_req(input int unsigned a[L], input logic [L-1:0] m,
                         input logic md, input string tag);
    int unsigned q[$];
    int unsigned w[$];
    int unsigned gb, al, wd;
    longint exp_util;
    int exp_cnt;
    bit hs, found;
    gb = md ? 32 : 128;
    for (int i = 0; i < L; i++) begin
      if (m[i]) begin
        al = a[i] & ~(gb - 1);
        found = 0;
        foreach (q[k]) if (q[k] == al) found = 1;
        if (!found) q.push_back(al);
        wd = a[i] >> 2;
        found = 0;
        foreach (w[k]) if (w[k] == wd) found = 1;
        if (!found) w.push_back(wd);
      end
    end
    q.sort();
    exp_cnt  = q.size();
    exp_util = (exp_cnt == 0) ? 0 : (longint'(w.size()) * 4 * 100000) / (longint'(exp_cnt) * gb);

    @(negedge clk);
    chk(req_ready == 1'b1, "R6", {tag, " ready before accept"}, req_ready, 1);
    for (int i = 0; i < L; i++) lane_addr[i*32 +: 32] = a[i];
    lane_mask = m;
    gran      = md;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lane_addr = {L{32'hDEAD_BEE0}};
    lane_mask = '1;
    hs = 0;
    forever begin
      if (hs) void'(q.pop_front());
      if (q.size() == 0) begin
        txn_ready = 1'b0;
        chk(txn_valid == 1'b0, "R3", {tag, " no extra request"}, txn_valid, 0);
        chk(req_ready == 1'b1, "R6", {tag, " ready after last"}, req_ready, 1);
        if (exp_cnt == 0) begin
          chk(stat_valid == 1'b0, "R7", {tag, " no report on empty mask"}, stat_valid, 0);
        end else begin
          chk(stat_valid == 1'b1, "R8", {tag, " report pulse"}, stat_valid, 1);
          chk(stat_cnt == 6'(exp_cnt), "R8", {tag, " request count"}, stat_cnt, exp_cnt);
          chk(longint'(util) == exp_util, "R9", {tag, " utilisation"}, util, exp_util);
          @(negedge clk);
          chk(stat_valid == 1'b0, "R8", {tag, " pulse one cycle"}, stat_valid, 0);
        end
        break;
      end
      chk(txn_valid == 1'b1, "R3", {tag, " request valid"}, txn_valid, 1);
      chk(txn_addr == q[0], md ? "R2" : "R1", {tag, " request address (R4 order)"}, txn_addr, q[0]);
      chk(txn_last == (q.size() == 1), "R4", {tag, " last flag"}, txn_last, q.size() == 1);
      chk(req_ready == 1'b0, "R6", {tag, " not ready while busy"}, req_ready, 0);
      hs = ($urandom_range(0, 3) != 0);
      txn_ready = hs;  // R5: stalled cycles recheck the same head
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned a[L];
    repeat (3) @(negedge clk);
    // R10
    chk(req_ready == 1'b1, "R10", "reset ready", req_ready, 1);
    chk(txn_valid == 1'b0, "R10", "reset txn_valid", txn_valid, 0);
    chk(stat_valid == 1'b0, "R10", "reset stat_valid", stat_valid, 0);
    rst_n = 1'b1;

    for (int i = 0; i < L; i++) a[i] = 32'h1000 + 4 * i;
    run_req(a, '1, 1'b0, "R1 aligned line");
    run_req(a, '1, 1'b1, "R2 aligned segs");
    for (int i = 0; i < L; i++) a[i] = 32'h1000 + 4 * ((i * 7) % L);
    run_req(a, '1, 1'b0, "R3 permuted");
    for (int i = 0; i < L; i++) a[i] = 32'h2010 + 4 * i;
    run_req(a, '1, 1'b0, "R9 unaligned line");
    run_req(a, '1, 1'b1, "R9 unaligned segs");
    for (int i = 0; i < L; i++) a[i] = 32'h4444;
    run_req(a, '1, 1'b1, "R9 same addr seg");
    run_req(a, '1, 1'b0, "R9 same addr line");
    for (int i = 0; i < L; i++) a[i] = 32'h10004 + (L - 1 - i) * 32'h200;
    run_req(a, '1, 1'b0, "R4 scattered");
    for (int i = 0; i < L; i++) a[i] = (i % 2 == 0) ? 32'h3000 + 4 * i : 32'hF000_0000 + 32'h100 * i;
    run_req(a, 32'h5555_5555, 1'b0, "R7 half mask line");
    run_req(a, 32'h5555_5555, 1'b1, "R7 half mask seg");
    run_req(a, '0, 1'b0, "R7 empty mask");
    for (int i = 0; i < L; i++) a[i] = 32'h8000 + 32'h40 * (i % 4) + 4 * (i / 4);
    run_req(a, '1, 1'b1, "R3 interleaved segs");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule